// File: doc/BRIEF.md
# Seconds Countdown Alarm

This block is a countdown alarm driven by an external one-second tick. Software loads the number of seconds that remain into a counter register. It then turns the countdown on. While the countdown runs, each tick lowers the counter by one.

The tick that takes the counter from one to zero latches a pending flag. The pending flag drives two outputs:
- an interrupt line, gated by its own enable bit;
- a wakeup line, gated by a separate enable bit.

The pending flag clears only when software writes a 1 to it. Clearing the flag does not depend on either enable.

All registers sit on a simple 32-bit register bus. A read returns data one cycle after it is requested. Tick generation and the logic that acts on the wakeup line are outside this block.

Top module: `cdalarm_top`

## Requirements
- R1: After a synchronous reset, the following are all 0: the counter, the three control bits, the pending flag, `irq_o`, `wake_o` and `bus_rdata`.
- R2: Register map (byte offsets, data in bit 0 unless noted):
  - counter at 0x20, all 32 bits;
  - countdown run at 0x28;
  - interrupt enable at 0x2C;
  - pending status at 0x30;
  - wakeup enable at 0x50.
  
  A read (`bus_sel`=1, `bus_wr`=0) returns data on `bus_rdata` in the next cycle. An unmapped offset reads 0.
- R3: While the run bit is 1 and the counter is non-zero, each cycle with `tick`=1 lowers the counter by exactly 1. With the run bit at 0, or with no tick, the counter keeps its value.
- R4: The tick that takes the counter from 1 to 0 sets the pending flag. Later ticks leave the counter at 0 and the flag set.
- R5: A counter of 0 never sets the pending flag. This holds whether 0 was loaded while stopped or while running, and whatever ticks follow.
- R6: Writing 1 to bit 0 at offset 0x30 clears the pending flag. Writing 0 there leaves it unchanged.
- R7: If a clearing write and a 1-to-0 tick fall in the same cycle, the pending flag stays set.
- R8: `irq_o` equals pending AND interrupt enable, registered so that it changes in the same cycle as those bits.
- R9: `wake_o` equals pending AND wakeup enable, independently of the interrupt enable.
- R10: A counter write in the same cycle as a tick loads the written value, with no decrement applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per elapsed second |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq_o | output | 1 | Alarm interrupt |
| wake_o | output | 1 | Alarm wakeup request |

## Verification
The bench builds the block with its default parameters: an 8-bit byte offset, a 32-bit data bus and a 32-bit counter. With these settings it can load the all-ones count and watch the first decrement from the top of the range. Short countdowns of one to five seconds bring the 1-to-0 edge, the hold at zero, and the same-cycle races within a few cycles. Those races are clear against a new event, and a load against a tick.

// File: rtl/cdalarm_pkg.sv
package cdalarm_pkg;
  localparam int unsigned OFS_W = 8;
  localparam logic [OFS_W-1:0] OFS_COUNT = 8'h20;
  localparam logic [OFS_W-1:0] OFS_STAT  = 8'h30;

  localparam int unsigned N_CTRL = 3;
  typedef enum int unsigned {
    CTRL_RUN  = 0,
    CTRL_IRQ  = 1,
    CTRL_WAKE = 2
  } ctrl_idx_e;
  localparam logic [OFS_W-1:0] CTRL_OFS [N_CTRL] = '{8'h28, 8'h2C, 8'h50};
endpackage

// File: rtl/cdalarm_counter.sv
module cdalarm_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             step;

  assign step   = run_i && tick && !load_i && (cnt_q != '0);
  assign fire_o = step && (cnt_q == ONE);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (step) begin
      cnt_q <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/cdalarm_regs.sv
module cdalarm_regs
  import cdalarm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              fire_i,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic [N_CTRL-1:0] ctrl_o,
  output logic              pend_o,
  output logic              irq_o,
  output logic              wake_o,
  output logic [DATA_W-1:0] bus_rdata
);
  logic              wr_en, rd_en, clr;
  logic [N_CTRL-1:0] ctrl_d, ctrl_q;
  logic              pend_d, pend_q;
  logic              irq_q, wake_q;
  logic [DATA_W-1:0] rd_mux, rdata_q;

  assign wr_en      = bus_sel && bus_wr;
  assign rd_en      = bus_sel && !bus_wr;
  assign load_o     = wr_en && (bus_addr == ADDR_W'(OFS_COUNT));
  assign load_val_o = bus_wdata[CNT_W-1:0];
  assign clr        = wr_en && (bus_addr == ADDR_W'(OFS_STAT)) && bus_wdata[0];

  for (genvar gi = 0; gi < N_CTRL; gi++) begin : g_ctrl
    assign ctrl_d[gi] = (wr_en && (bus_addr == ADDR_W'(CTRL_OFS[gi])))
                        ? bus_wdata[0] : ctrl_q[gi];
  end

  // a new event outranks a clear in the same cycle
  assign pend_d = fire_i ? 1'b1 : (clr ? 1'b0 : pend_q);

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(OFS_COUNT)) rd_mux = DATA_W'(cnt_i);
    if (bus_addr == ADDR_W'(OFS_STAT))  rd_mux = DATA_W'(pend_q);
    for (int i = 0; i < N_CTRL; i++) begin
      if (bus_addr == ADDR_W'(CTRL_OFS[i])) rd_mux = DATA_W'(ctrl_q[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      pend_q  <= 1'b0;
      irq_q   <= 1'b0;
      wake_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      pend_q  <= pend_d;
      irq_q   <= pend_d && ctrl_d[CTRL_IRQ];
      wake_q  <= pend_d && ctrl_d[CTRL_WAKE];
      rdata_q <= rd_en ? rd_mux : '0;
    end
  end

  assign ctrl_o    = ctrl_q;
  assign pend_o    = pend_q;
  assign irq_o     = irq_q;
  assign wake_o    = wake_q;
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/cdalarm_top.sv
module cdalarm_top
  import cdalarm_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              wake_o
);
  logic              load_w, fire_w, pend_w;
  logic [CNT_W-1:0]  load_val_w, cnt_w;
  logic [N_CTRL-1:0] ctrl_w;

  cdalarm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_i(cnt_w),
    .fire_i(fire_w), .load_o(load_w), .load_val_o(load_val_w),
    .ctrl_o(ctrl_w), .pend_o(pend_w), .irq_o(irq_o), .wake_o(wake_o),
    .bus_rdata(bus_rdata)
  );

  cdalarm_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .tick(tick), .run_i(ctrl_w[CTRL_RUN]),
    .load_i(load_w), .load_val_i(load_val_w), .cnt_o(cnt_w),
    .fire_o(fire_w)
  );
endmodule

// File: rtl/cdalarm_chk.sv
module cdalarm_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             run,
  input logic             irq_en,
  input logic             wake_en,
  input logic             load,
  input logic [CNT_W-1:0] load_val,
  input logic [CNT_W-1:0] cnt,
  input logic             pend,
  input logic             irq_o,
  input logic             wake_o
);
  // R3: one tick, one step down
  p_dec_r3: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !load && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));
  // R3: no tick or stopped, no change
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!load && !(run && tick)) |=> $stable(cnt));
  // R4: final tick latches pending
  p_fire_r4: assert property (@(posedge clk) disable iff (rst)
    (run && tick && !load && cnt == CNT_W'(1)) |=> (pend && cnt == '0));
  // R5: zero count never raises pending
  p_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (!pend && cnt == '0 && !load) |=> !pend);
  // R10: load wins over tick
  p_load_r10: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val)));
  // R8
  p_irq_r8: assert property (@(posedge clk) disable iff (rst)
    irq_o == (pend && irq_en));
  // R9
  p_wake_r9: assert property (@(posedge clk) disable iff (rst)
    wake_o == (pend && wake_en));
endmodule

bind cdalarm_top cdalarm_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .tick(tick), .run(ctrl_w[0]), .irq_en(ctrl_w[1]),
  .wake_en(ctrl_w[2]), .load(load_w), .load_val(load_val_w), .cnt(cnt_w),
  .pend(pend_w), .irq_o(irq_o), .wake_o(wake_o)
);

// File: tb/cdalarm_top_tb_top.sv
module cdalarm_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, wake_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_CNT = 8'h20, A_RUN = 8'h28, A_IE = 8'h2C,
                         A_ST = 8'h30, A_WK = 8'h50;

  always #4 clk = ~clk;

  cdalarm_top dut_i (
    .clk(clk), .rst(rst), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic tk = 1'b0);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick = tk;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq", 32'(irq_o), 0);
    check("R1 wake", 32'(wake_o), 0);
    check("R1 rdata", bus_rdata, 0);
    rd(A_CNT, d); check("R1 counter", d, 0);
    rd(A_ST, d);  check("R1 pending", d, 0);
    rd(A_RUN, d); check("R1 run", d, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(A_CNT, 32'h1234_5678); rd(A_CNT, d); check("R2 counter rb", d, 32'h1234_5678);
    wr(A_IE, 1); rd(A_IE, d); check("R2 irq en rb", d, 1);
    wr(A_WK, 1); rd(A_WK, d); check("R2 wake en rb", d, 1);
    rd(8'h40, d); check("R2 unmapped", d, 0);
    wr(A_IE, 0); wr(A_WK, 0);
    rd(A_IE, d); check("R2 irq en clr", d, 0);
  endtask

  task automatic t_count;
    logic [31:0] d;
    wr(A_CNT, 5); ticks(3);
    rd(A_CNT, d); check("R3 stopped hold", d, 5);
    wr(A_RUN, 1); ticks(2);
    rd(A_CNT, d); check("R3 decrement", d, 3);
    repeat (4) @(negedge clk);
    rd(A_CNT, d); check("R3 no tick hold", d, 3);
    ticks(2); rd(A_ST, d); check("R4 not yet", d, 0);
    ticks(1); rd(A_ST, d); check("R4 pending set", d, 1);
    ticks(2); rd(A_CNT, d); check("R4 hold zero", d, 0);
    rd(A_ST, d); check("R4 stays set", d, 1);
    wr(A_ST, 0); rd(A_ST, d); check("R6 write 0 no effect", d, 1);
    wr(A_ST, 1); rd(A_ST, d); check("R6 clear", d, 0);
  endtask

  task automatic t_zero;
    logic [31:0] d;
    wr(A_RUN, 0); wr(A_CNT, 0); ticks(2);
    rd(A_ST, d); check("R5 zero stopped", d, 0);
    wr(A_RUN, 1); ticks(3);
    rd(A_ST, d); check("R5 zero running", d, 0);
    wr(A_CNT, 0); ticks(1);
    rd(A_ST, d); check("R5 zero load running", d, 0);
  endtask

  task automatic t_outs;
    wr(A_CNT, 1); ticks(1);
    check("R8 irq off", 32'(irq_o), 0);
    check("R9 wake off", 32'(wake_o), 0);
    wr(A_IE, 1);
    check("R8 irq on", 32'(irq_o), 1);
    check("R9 wake not from ie", 32'(wake_o), 0);
    wr(A_IE, 0); wr(A_WK, 1);
    check("R8 irq gated", 32'(irq_o), 0);
    check("R9 wake on", 32'(wake_o), 1);
    wr(A_IE, 1); wr(A_ST, 1);
    check("R8 irq after clear", 32'(irq_o), 0);
    check("R9 wake after clear", 32'(wake_o), 0);
    wr(A_IE, 0); wr(A_WK, 0);
  endtask

  task automatic t_race;
    logic [31:0] d;
    wr(A_CNT, 1); ticks(1);
    rd(A_ST, d); check("R7 setup pending", d, 1);
    wr(A_CNT, 1);
    wr(A_ST, 1, 1'b1);
    rd(A_ST, d); check("R7 event beats clear", d, 1);
    rd(A_CNT, d); check("R7 counter reached 0", d, 0);
    wr(A_ST, 1); rd(A_ST, d); check("R7 later clear", d, 0);
  endtask

  task automatic t_load_tick;
    logic [31:0] d;
    wr(A_CNT, 7);
    wr(A_CNT, 20, 1'b1);
    rd(A_CNT, d); check("R10 load over tick", d, 20);
    wr(A_CNT, 32'hFFFF_FFFF); ticks(1);
    rd(A_CNT, d); check("R3 top of range", d, 32'hFFFF_FFFE);
    rd(A_ST, d); check("R10 no pending", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_count();
    t_zero();
    t_outs();
    t_race();
    t_load_tick();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule